// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Latch

This block turns a serial bit stream into eight drive-enable lines for low-side loads such as LEDs or relays. Bits arrive on a serial input and move through a shift chain on each rising edge of a shift clock. A separate storage clock copies the whole chain into a holding bank. The holding bank drives the outputs through an active-low output enable. A 1 on an output means the sink transistor for that load is on.

An active-low clear empties the shift chain, the holding bank and the cascade flop at once, and it does not wait for a clock. The last shift stage is brought out on a cascade pin, and that pin is launched on the falling shift-clock edge. A downstream copy sampling on the next rising edge therefore gets half a period of hold margin. Several copies wired in a chain behave as one longer shift register.

Top module: `spo_latch_driver`

## Requirements
- R1: On each rising edge of `sclk`, `ser_in` enters stage 0 and every stage moves up one place. A bit shifted in first reaches stage 7 (output index 7) after eight rising edges, so a byte sent most-significant bit first lands with bit i in stage i.
- R2: On each rising edge of `lclk`, all stages of the shift chain are copied into the holding bank. Shifting without an `lclk` edge leaves `sink_on` unchanged.
- R3: While `clr_n` is 0, the shift chain, the holding bank and `casc_out` are all 0. The clear acts without any clock edge, and clock edges during clear have no effect.
- R4: While `oe_n` is 1, every bit of `sink_on` is 0, whatever the holding bank contains.
- R5: While `oe_n` is 0, `sink_on[i]` equals holding-bank bit i. A 1 turns the sink on and a 0 leaves it off.
- R6: `casc_out` shows stage 7 and changes only on a falling edge of `sclk`. Just after a rising edge it still shows the value from before that edge.
- R7: When `sclk` and `lclk` rise on the same edge, the holding bank receives the chain contents from before that edge.
- R8: Two copies chained through `casc_out` into the next copy's `ser_in`, after 16 shifts, hold the first byte in the downstream copy and the second byte in the upstream copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data bit sampled on rising `sclk` |
| sclk | input | 1 | Shift clock |
| lclk | input | 1 | Storage clock; rising edge copies the chain into the holding bank |
| clr_n | input | 1 | Active-low asynchronous clear of all state |
| oe_n | input | 1 | Active-low output enable |
| sink_on | output | WIDTH | Drive enables, 1 = sink transistor on |
| casc_out | output | 1 | Last shift stage, launched on falling `sclk` |

## Verification
A shift result is due at the rising `sclk` edge. A holding-bank result appears on `sink_on` right after the rising `lclk` edge, because the output gating is combinational. `casc_out` moves only after the following falling `sclk` edge, and clear and `oe_n` act with no clock at all. The bench changes inputs only at falling edges of its 50 MHz reference. It samples outputs 2 ns after a falling edge, or 2 ns after a rising edge when it proves that `casc_out` has not yet moved. Each check therefore lands after the edge that should have produced its result and before the next one.

// File: rtl/spo_pkg.sv
// Package: shared constants of the serial-to-parallel output latch.
// Assumes: nothing; it only holds the default stage count.
package spo_pkg;
    localparam int unsigned SPO_DEF_WIDTH = 8;
endpackage

// File: rtl/spo_shift_chain.sv
// Shift chain: serial-in, parallel-out stages clocked on rising sclk.
// Assumes: clr_n is asynchronous and active low; WIDTH >= 2.
module spo_shift_chain #(
    parameter int unsigned WIDTH = spo_pkg::SPO_DEF_WIDTH
) (
    input  logic             sclk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages
);
    // Purpose: move every stage up one place and take din into stage 0.
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            stages <= '0;
        end else begin
            stages <= {stages[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/spo_hold_bank.sv
// Holding bank: parallel copy of the shift chain on rising lclk.
// Assumes: clr_n is asynchronous and active low and is shared with the chain.
module spo_hold_bank #(
    parameter int unsigned WIDTH = spo_pkg::SPO_DEF_WIDTH
) (
    input  logic             lclk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Purpose: capture all chain stages at once.
    always_ff @(posedge lclk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spo_cascade_tap.sv
// Cascade tap: retimes the last shift stage onto falling sclk.
// Assumes: the downstream stage samples on rising sclk, so half a period
// of hold margin is gained.
module spo_cascade_tap (
    input  logic sclk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    // Purpose: launch the top stage on the falling shift edge.
    always_ff @(negedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spo_drive_gate.sv
// Drive gate: masks each held bit with the active-low output enable.
// Assumes: purely combinational; one gate per output.
module spo_drive_gate #(
    parameter int unsigned WIDTH = spo_pkg::SPO_DEF_WIDTH
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] drv
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Purpose: turn the sink on only when enabled and the bit is set.
        assign drv[b] = held[b] & ~oe_n;
    end
endmodule

// File: rtl/spo_latch_driver.sv
// Top: cascadable serial-to-parallel output latch with gated drive enables.
// Assumes: sclk and lclk may be independent or the same net; clr_n is
// asynchronous and clears every flop; oe_n only masks, it never clears.
module spo_latch_driver #(
    parameter int unsigned WIDTH = spo_pkg::SPO_DEF_WIDTH
) (
    input  logic             ser_in,
    input  logic             sclk,
    input  logic             lclk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] sink_on,
    output logic             casc_out
);
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] hold_q;

    spo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .sclk   (sclk),
        .clr_n  (clr_n),
        .din    (ser_in),
        .stages (shift_q)
    );

    spo_hold_bank #(.WIDTH(WIDTH)) u_hold (
        .lclk  (lclk),
        .clr_n (clr_n),
        .d     (shift_q),
        .q     (hold_q)
    );

    spo_cascade_tap u_tap (
        .sclk  (sclk),
        .clr_n (clr_n),
        .d     (shift_q[WIDTH-1]),
        .q     (casc_out)
    );

    spo_drive_gate #(.WIDTH(WIDTH)) u_gate (
        .oe_n (oe_n),
        .held (hold_q),
        .drv  (sink_on)
    );
endmodule

// File: rtl/spo_latch_driver_chk.sv
// Checker: temporal properties of the output latch, bound to the top.
// Assumes: sees the internal chain and holding bank through the bind.
module spo_latch_driver_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             ser_in,
    input logic             sclk,
    input logic             lclk,
    input logic             clr_n,
    input logic             oe_n,
    input logic [WIDTH-1:0] sink_on,
    input logic             casc_out,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] hold_q
);
    logic ok_sh, ok_ld, ok_tap;

    // Purpose: mark that the previous rising sclk came with no clear since.
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) ok_sh <= 1'b0;
        else        ok_sh <= 1'b1;
    end

    // Purpose: the same mark for the storage clock.
    always_ff @(posedge lclk or negedge clr_n) begin
        if (!clr_n) ok_ld <= 1'b0;
        else        ok_ld <= 1'b1;
    end

    // Purpose: the same mark for the falling shift edge.
    always_ff @(negedge sclk or negedge clr_n) begin
        if (!clr_n) ok_tap <= 1'b0;
        else        ok_tap <= 1'b1;
    end

    a_r1_shift_step: assert property (@(posedge sclk) disable iff (!clr_n)
        ok_sh |-> shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)});

    a_r2_hold_copy: assert property (@(posedge lclk) disable iff (!clr_n)
        ok_ld |-> hold_q == $past(shift_q));

    a_r3_clear_empty: assert property (@(posedge lclk) disable iff (clr_n)
        shift_q == '0 && hold_q == '0 && casc_out == 1'b0);

    a_r4_disabled_off: assert property (@(posedge sclk) disable iff (!clr_n)
        oe_n |-> sink_on == '0);

    a_r5_enabled_follow: assert property (@(posedge sclk) disable iff (!clr_n)
        !oe_n |-> sink_on == hold_q);

    a_r6_tap_fall: assert property (@(negedge sclk) disable iff (!clr_n)
        ok_tap |-> casc_out == $past(shift_q[WIDTH-1]));
endmodule

bind spo_latch_driver spo_latch_driver_chk #(.WIDTH(WIDTH)) u_chk (
    .ser_in   (ser_in),
    .sclk     (sclk),
    .lclk     (lclk),
    .clr_n    (clr_n),
    .oe_n     (oe_n),
    .sink_on  (sink_on),
    .casc_out (casc_out),
    .shift_q  (shift_q),
    .hold_q   (hold_q)
);

// File: tb/spo_latch_driver_tb_top.sv
// Bench: two chained copies, a vector table, then directed corner tests.
module spo_latch_driver_tb_top;
    localparam int W = 8;
    localparam int NVEC = 5;
    // Vector fields: {data to shift, oe_n, expected upstream sink_on}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 8'hA5},
        {8'h3C, 1'b0, 8'h3C},
        {8'hFF, 1'b1, 8'h00},
        {8'h01, 1'b0, 8'h01},
        {8'h80, 1'b0, 8'h80}
    };

    logic clk = 1'b0;
    logic sh_en = 1'b0;
    logic ld_en = 1'b0;
    logic ser_in = 1'b0;
    logic clr_n = 1'b0;
    logic oe_n = 1'b0;
    logic sclk, lclk;
    logic [W-1:0] sink_a, sink_b;
    logic casc_a, casc_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign sclk = clk & sh_en;
    assign lclk = clk & ld_en;

    spo_latch_driver #(.WIDTH(W)) dut_i (
        .ser_in(ser_in), .sclk(sclk), .lclk(lclk), .clr_n(clr_n),
        .oe_n(oe_n), .sink_on(sink_a), .casc_out(casc_a));

    spo_latch_driver #(.WIDTH(W)) dut_b (
        .ser_in(casc_a), .sclk(sclk), .lclk(lclk), .clr_n(clr_n),
        .oe_n(oe_n), .sink_on(sink_b), .casc_out(casc_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send a byte most-significant bit first, optionally loading on the last edge.
    task automatic shift_byte(input logic [W-1:0] d, input bit load_last);
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_in = d[i];
            sh_en = 1'b1;
            if (i == 0 && load_last) ld_en = 1'b1;
        end
        @(negedge clk);
        sh_en = 1'b0;
        ld_en = 1'b0;
        #2;
    endtask

    task automatic load_pulse();
        @(negedge clk);
        ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
        #2;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev;
        #5;
        // Reset state (R3)
        check("R3 reset sink", {24'h0, sink_a}, 32'h0);
        check("R3 reset casc", {31'h0, casc_a}, 32'h0);
        @(negedge clk);
        clr_n = 1'b1;

        // Vector table: R1, R4, R5, R8
        prev = '0;
        for (int v = 0; v < NVEC; v++) begin
            oe_n = VEC[v][8];
            shift_byte(VEC[v][16:9], 1'b0);
            load_pulse();
            check("R1/R5 table upstream", {24'h0, sink_a}, {24'h0, VEC[v][7:0]});
            check("R8 table downstream", {24'h0, sink_b}, {24'h0, (VEC[v][8] ? 8'h00 : prev)});
            prev = VEC[v][16:9];
        end

        // R2: shifting without a storage edge leaves outputs alone
        shift_byte(8'h5A, 1'b0);
        check("R2 no load", {24'h0, sink_a}, 32'h80);
        load_pulse();
        check("R2 load", {24'h0, sink_a}, 32'h5A);

        // R4 then R5: enable toggled with no clock
        oe_n = 1'b1;
        #2 check("R4 disabled", {24'h0, sink_a}, 32'h0);
        oe_n = 1'b0;
        #2 check("R5 re-enabled", {24'h0, sink_a}, 32'h5A);

        // R6: cascade moves only on the falling edge
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        ser_in = 1'b1;
        sh_en = 1'b1;
        for (int i = 0; i < W - 1; i++) begin
            @(negedge clk);
            ser_in = 1'b0;
        end
        @(posedge clk);
        #2 check("R6 casc before fall", {31'h0, casc_a}, 32'h0);
        @(negedge clk);
        sh_en = 1'b0;
        #2 check("R6 casc after fall", {31'h0, casc_a}, 32'h1);
        load_pulse();
        check("R1 first bit at top", {24'h0, sink_a}, 32'h80);

        // R3: asynchronous clear, storage edges during clear ignored
        #3 clr_n = 1'b0;
        #1 check("R3 async sink", {24'h0, sink_a}, 32'h0);
        check("R3 async casc", {31'h0, casc_a}, 32'h0);
        load_pulse();
        check("R3 load during clear", {24'h0, sink_a}, 32'h0);
        @(negedge clk);
        clr_n = 1'b1;
        load_pulse();
        check("R3 chain emptied", {24'h0, sink_a}, 32'h0);

        // R7: shared edge captures pre-edge chain
        shift_byte(8'hB6, 1'b1);
        check("R7 shared edge", {24'h0, sink_a}, 32'h5B);
        load_pulse();
        check("R7 later load", {24'h0, sink_a}, 32'hB6);

        // R8: 16-bit chain
        shift_byte(8'hC3, 1'b0);
        shift_byte(8'h96, 1'b0);
        load_pulse();
        check("R8 downstream first byte", {24'h0, sink_b}, 32'hC3);
        check("R8 upstream second byte", {24'h0, sink_a}, 32'h96);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule